// File: doc/BRIEF.md
# Video Clamp and Gain Loop Controller

This block watches an 8-bit luminance stream and an 8-bit chrominance stream and closes three digital correction loops that hold the video at fixed code levels. A sync-window gate drives the luminance gain loop toward the sync-tip code. A separate rear-porch gate drives the luminance offset loop toward the black code and the chrominance offset loop toward the mid-scale code. Each loop is a 10-bit saturating integrator. It stands in for the charge on an external hold capacitor, and it reports every step through registered charge and discharge strobes.

A peak-white limiter is enabled by an active-low input. When enabled, it pulls the gain loop down whenever luminance reaches full scale. If the two gates overlap, the block flags an error and freezes all loops for that cycle. After reset, a fast-start mode multiplies the loop step for the first gate windows. A status bit reports whether the measured black-to-sync-tip distance is close to its nominal value. A registered output stage presents each channel in straight binary or in two's complement.

Top module: `vid_level_ctrl`

## Requirements
- R1: With the sync gate high, the porch gate low and a valid Y sample, the gain word rises by one step if the sample is above code 1, falls by one step if it is below code 1, and holds if it equals 1. The matching up or down strobe is high in the cycle after the sample.
- R2: With the porch gate high, the sync gate low and a valid Y sample, the Y offset word rises by one step for a sample below code 64, falls by one step above 64, and holds at 64. It drives its own up/down strobes.
- R3: In the same porch window, a valid C sample moves the C offset word up by one step below code 128, down by one step above 128, and leaves it unchanged at 128. It drives its own strobes.
- R4: With the peak-white enable low, a valid Y sample of 255 forces a one-step gain decrease and the gain down strobe, in or out of any window. This takes priority over a sync-window increase. With the enable high, such a sample has no peak-white effect.
- R5: If both gates are high in the same cycle, gate_err_o is high in the next cycle and no integrator moves or strobes in that cycle.
- R6: Outside both windows (absent peak-white), or with the sample's valid low, every integrator holds and every strobe is low.
- R7: Integrators saturate at 0 and 1023 and never wrap.
- R8: The step is 8 until 16 gate windows have ended, then 1. A window ends on a falling edge of either gate.
- R9: On each falling edge of the porch gate, sync_ok_o is set if the last porch Y sample minus the last sync Y sample lies in 62..66, and is cleared otherwise. Only samples from non-overlapping windows are captured.
- R10: A format bit of 0 gives straight binary and 1 gives two's complement (MSB inverted). The formatted word is registered on each valid sample and held otherwise.
- R11: After reset, all integrators read 512, and all strobes, gate_err_o, sync_ok_o and the formatted outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| y_valid_i | input | 1 | Y sample valid |
| y_data_i | input | 8 | Y sample, binary |
| c_valid_i | input | 1 | C sample valid |
| c_data_i | input | 8 | C sample, binary |
| sync_gate_i | input | 1 | Sync-tip window gate |
| porch_gate_i | input | 1 | Rear-porch window gate |
| pw_en_ni | input | 1 | Peak-white limiter enable, active low |
| y_twos_i | input | 1 | Y output format, 1 = two's complement |
| c_twos_i | input | 1 | C output format, 1 = two's complement |
| y_gain_o | output | 10 | Y gain integrator |
| y_ofs_o | output | 10 | Y offset integrator |
| c_ofs_o | output | 10 | C offset integrator |
| y_gain_up_o | output | 1 | Gain charge strobe |
| y_gain_dn_o | output | 1 | Gain discharge strobe |
| y_ofs_up_o | output | 1 | Y offset charge strobe |
| y_ofs_dn_o | output | 1 | Y offset discharge strobe |
| c_ofs_up_o | output | 1 | C offset charge strobe |
| c_ofs_dn_o | output | 1 | C offset discharge strobe |
| y_fmt_o | output | 8 | Formatted Y sample |
| c_fmt_o | output | 8 | Formatted C sample |
| gate_err_o | output | 1 | Overlapping gates seen last cycle |
| sync_ok_o | output | 1 | Sync amplitude within tolerance |

## Verification
The assertions assume that the gate inputs are synchronous to the sample clock and free of glitches. They also assume that a gate is never high in the cycle reset is released. The overlap case is the only illegal gate combination, and it is flagged rather than assumed away. The stimulus changes every input on the falling clock edge, opens each window for one or more whole cycles, and creates overlap only on purpose in the R5 case. A cycle model in the bench tracks each integrator, the window count and the captured levels, so every cycle is compared against values derived from the requirements.

// File: rtl/vca_pkg.sv
package vca_pkg;
  localparam int DATA_W = 8;
  localparam int INTG_W = 10;
  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DN} dir_e;
endpackage

// File: rtl/vca_loop.sv
module vca_loop import vca_pkg::*; #(
  parameter int              DW       = 8,
  parameter int              IW       = 10,
  parameter logic [DW-1:0]   TGT      = '0,
  parameter bit              ABOVE_UP = 1'b1,
  parameter int              INIT     = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          force_dn_i,
  input  logic [DW-1:0] sample_i,
  input  logic [IW-1:0] step_i,
  output logic [IW-1:0] val_o,
  output logic          up_o,
  output logic          dn_o
);
  localparam logic [IW-1:0] VMAX  = '1;
  localparam logic [IW-1:0] VINIT = IW'(INIT);

  dir_e          dir;
  logic [IW:0]   inc_w;
  logic [IW-1:0] nxt, val_q;
  logic          up_q, dn_q;

  always_comb begin
    dir = DIR_HOLD;
    if (force_dn_i)                   dir = DIR_DN;
    else if (en_i && sample_i > TGT)  dir = ABOVE_UP ? DIR_UP : DIR_DN;
    else if (en_i && sample_i < TGT)  dir = ABOVE_UP ? DIR_DN : DIR_UP;
  end

  assign inc_w = {1'b0, val_q} + {1'b0, step_i};

  always_comb begin
    case (dir)
      DIR_UP:  nxt = inc_w[IW] ? VMAX : inc_w[IW-1:0];
      DIR_DN:  nxt = (val_q < step_i) ? '0 : val_q - step_i;
      default: nxt = val_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= VINIT;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      val_q <= nxt;
      up_q  <= (dir == DIR_UP);
      dn_q  <= (dir == DIR_DN);
    end
  end

  assign val_o = val_q;
  assign up_o  = up_q;
  assign dn_o  = dn_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !force_dn_i) |=> ($stable(val_o) && !up_o && !dn_o));
  a_r7_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> (val_o >= $past(val_o)));
  a_r7_no_wrap_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |-> (val_o <= $past(val_o)));
  a_r8_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((val_o >= $past(val_o)) ? (val_o - $past(val_o))
                                       : ($past(val_o) - val_o)) <= $past(step_i)));
endmodule

// File: rtl/vca_prechg.sv
module vca_prechg #(
  parameter int IW      = 10,
  parameter int PRE_WIN = 16,
  parameter int PRE_MUL = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_gate_i,
  input  logic          porch_gate_i,
  output logic [IW-1:0] step_o,
  output logic          porch_fall_o
);
  localparam int CW = $clog2(PRE_WIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(PRE_WIN);

  logic          s_q, p_q, any_fall;
  logic [CW-1:0] cnt_q;

  assign porch_fall_o = p_q & ~porch_gate_i;
  assign any_fall     = (s_q & ~sync_gate_i) | porch_fall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= 1'b0;
      p_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      s_q <= sync_gate_i;
      p_q <= porch_gate_i;
      if (any_fall && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_o = (cnt_q < CMAX) ? IW'(PRE_MUL) : IW'(1);

  a_r8_count_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_fall |=> $stable(cnt_q));
  a_r8_step_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == IW'(PRE_MUL)) || (step_o == IW'(1)));
endmodule

// File: rtl/vca_syncmeas.sv
module vca_syncmeas #(
  parameter int DW  = 8,
  parameter int NOM = 64,
  parameter int TOL = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tip_cap_i,
  input  logic          blk_cap_i,
  input  logic [DW-1:0] y_i,
  input  logic          porch_fall_i,
  output logic          ok_o
);
  localparam logic signed [DW:0] LO = (DW+1)'(NOM - TOL);
  localparam logic signed [DW:0] HI = (DW+1)'(NOM + TOL);

  logic [DW-1:0]    tip_q, blk_q;
  logic signed [DW:0] diff;
  logic             ok_q;

  assign diff = $signed({1'b0, blk_q}) - $signed({1'b0, tip_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q <= '0;
      blk_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      if (tip_cap_i)    tip_q <= y_i;
      if (blk_cap_i)    blk_q <= y_i;
      if (porch_fall_i) ok_q  <= (diff >= LO) && (diff <= HI);
    end
  end

  assign ok_o = ok_q;

  a_r9_update_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !porch_fall_i |=> $stable(ok_o));
endmodule

// File: rtl/vca_fmt.sv
module vca_fmt #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          twos_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (valid_i) data_q <= {data_i[DW-1] ^ twos_i, data_i[DW-2:0]};
  end

  assign data_o = data_q;

  a_r10_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (data_o[DW-2:0] == $past(data_i[DW-2:0])));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/vid_level_ctrl.sv
module vid_level_ctrl #(
  parameter int DW       = vca_pkg::DATA_W,
  parameter int IW       = vca_pkg::INTG_W,
  parameter int TIP_CODE = 1,
  parameter int BLK_CODE = 64,
  parameter int CHR_CODE = 128,
  parameter int INIT     = 512,
  parameter int PRE_WIN  = 16,
  parameter int PRE_MUL  = 8,
  parameter int AMP_NOM  = 64,
  parameter int AMP_TOL  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          y_valid_i,
  input  logic [DW-1:0] y_data_i,
  input  logic          c_valid_i,
  input  logic [DW-1:0] c_data_i,
  input  logic          sync_gate_i,
  input  logic          porch_gate_i,
  input  logic          pw_en_ni,
  input  logic          y_twos_i,
  input  logic          c_twos_i,
  output logic [IW-1:0] y_gain_o,
  output logic [IW-1:0] y_ofs_o,
  output logic [IW-1:0] c_ofs_o,
  output logic          y_gain_up_o,
  output logic          y_gain_dn_o,
  output logic          y_ofs_up_o,
  output logic          y_ofs_dn_o,
  output logic          c_ofs_up_o,
  output logic          c_ofs_dn_o,
  output logic [DW-1:0] y_fmt_o,
  output logic [DW-1:0] c_fmt_o,
  output logic          gate_err_o,
  output logic          sync_ok_o
);
  localparam int NCH = 2;

  logic          overlap, sync_win, porch_win, pw_hit;
  logic          g_en, yo_en, co_en;
  logic [IW-1:0] step;
  logic          porch_fall;
  logic          err_q;

  assign overlap   = sync_gate_i & porch_gate_i;
  assign sync_win  = sync_gate_i & ~porch_gate_i;
  assign porch_win = porch_gate_i & ~sync_gate_i;
  assign g_en      = sync_win & y_valid_i;
  assign yo_en     = porch_win & y_valid_i;
  assign co_en     = porch_win & c_valid_i;
  // limiter acts on any valid full-scale sample, never during overlap
  assign pw_hit    = ~pw_en_ni & y_valid_i & (&y_data_i) & ~overlap;

  vca_prechg #(.IW(IW), .PRE_WIN(PRE_WIN), .PRE_MUL(PRE_MUL)) u_pre (
    .clk_i, .rst_ni, .sync_gate_i, .porch_gate_i,
    .step_o(step), .porch_fall_o(porch_fall));

  vca_loop #(.DW(DW), .IW(IW), .TGT(DW'(TIP_CODE)), .ABOVE_UP(1'b1), .INIT(INIT)) u_gain (
    .clk_i, .rst_ni, .en_i(g_en), .force_dn_i(pw_hit), .sample_i(y_data_i),
    .step_i(step), .val_o(y_gain_o), .up_o(y_gain_up_o), .dn_o(y_gain_dn_o));

  vca_loop #(.DW(DW), .IW(IW), .TGT(DW'(BLK_CODE)), .ABOVE_UP(1'b0), .INIT(INIT)) u_yofs (
    .clk_i, .rst_ni, .en_i(yo_en), .force_dn_i(1'b0), .sample_i(y_data_i),
    .step_i(step), .val_o(y_ofs_o), .up_o(y_ofs_up_o), .dn_o(y_ofs_dn_o));

  vca_loop #(.DW(DW), .IW(IW), .TGT(DW'(CHR_CODE)), .ABOVE_UP(1'b0), .INIT(INIT)) u_cofs (
    .clk_i, .rst_ni, .en_i(co_en), .force_dn_i(1'b0), .sample_i(c_data_i),
    .step_i(step), .val_o(c_ofs_o), .up_o(c_ofs_up_o), .dn_o(c_ofs_dn_o));

  vca_syncmeas #(.DW(DW), .NOM(AMP_NOM), .TOL(AMP_TOL)) u_meas (
    .clk_i, .rst_ni, .tip_cap_i(g_en), .blk_cap_i(yo_en), .y_i(y_data_i),
    .porch_fall_i(porch_fall), .ok_o(sync_ok_o));

  logic [NCH-1:0][DW-1:0] fmt_in, fmt_out;
  logic [NCH-1:0]         fmt_vld, fmt_twos;
  assign fmt_in   = {c_data_i, y_data_i};
  assign fmt_vld  = {c_valid_i, y_valid_i};
  assign fmt_twos = {c_twos_i, y_twos_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_fmt
    vca_fmt #(.DW(DW)) u_fmt (
      .clk_i, .rst_ni, .valid_i(fmt_vld[ch]), .twos_i(fmt_twos[ch]),
      .data_i(fmt_in[ch]), .data_o(fmt_out[ch]));
  end
  assign y_fmt_o = fmt_out[0];
  assign c_fmt_o = fmt_out[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= overlap;
  end
  assign gate_err_o = err_q;

  a_r5_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_gate_i && porch_gate_i) |=> gate_err_o);
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_gate_i && porch_gate_i) |=> ($stable(y_gain_o) && $stable(y_ofs_o) && $stable(c_ofs_o)
      && !y_gain_up_o && !y_gain_dn_o && !y_ofs_up_o && !y_ofs_dn_o && !c_ofs_up_o && !c_ofs_dn_o));
  a_r4_pw_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pw_en_ni && y_valid_i && (&y_data_i) && !(sync_gate_i && porch_gate_i))
      |=> (y_gain_dn_o && !y_gain_up_o));
  a_r1_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({y_gain_up_o, y_gain_dn_o}) <= 1);
endmodule

// File: tb/sim_vid_level_ctrl.sv
module sim_vid_level_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic yv = 0, cv = 0, sg = 0, pg = 0, pw_n = 1, yt = 0, ct = 0;
  logic [7:0] yd = 0, cd = 0;
  logic [9:0] y_gain, y_ofs, c_ofs;
  logic g_up, g_dn, yo_up, yo_dn, co_up, co_dn, gerr, sok;
  logic [7:0] yf, cf;

  always #(CLK_P/2) clk = ~clk;

  vid_level_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .y_valid_i(yv), .y_data_i(yd), .c_valid_i(cv), .c_data_i(cd),
    .sync_gate_i(sg), .porch_gate_i(pg), .pw_en_ni(pw_n), .y_twos_i(yt), .c_twos_i(ct),
    .y_gain_o(y_gain), .y_ofs_o(y_ofs), .c_ofs_o(c_ofs),
    .y_gain_up_o(g_up), .y_gain_dn_o(g_dn), .y_ofs_up_o(yo_up), .y_ofs_dn_o(yo_dn),
    .c_ofs_up_o(co_up), .c_ofs_dn_o(co_dn), .y_fmt_o(yf), .c_fmt_o(cf),
    .gate_err_o(gerr), .sync_ok_o(sok));

  int nchk = 0, nerr = 0;
  int m_g = 512, m_yo = 512, m_co = 512, wins = 0;
  int m_gd = 0, m_od = 0, m_cd = 0;
  logic m_err = 0, m_ok = 0, ps = 0, pp = 0;
  logic [7:0] m_tip = 0, m_blk = 0, m_yf = 0, m_cf = 0;
  bit done = 0;

  // {fmt, data, expected}
  localparam logic [16:0] FMT_TAB [0:7] = '{
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h80}, {1'b0, 8'h7F, 8'h7F}, {1'b1, 8'h7F, 8'hFF},
    {1'b0, 8'h80, 8'h80}, {1'b1, 8'h80, 8'h00}, {1'b0, 8'hFF, 8'hFF}, {1'b1, 8'hFF, 8'h7F}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
  endfunction

  function automatic int sdir(input logic up, input logic dn);
    return up ? 1 : (dn ? -1 : 0);
  endfunction

  task automatic cyc(input logic s, p, y_v, c_v, input logic [7:0] y, c);
    int st, diff;
    logic pw, fall;
    @(negedge clk);
    sg = s; pg = p; yv = y_v; cv = c_v; yd = y; cd = c;
    m_err = s & p;
    st = (wins < 16) ? 8 : 1;
    pw = !pw_n && y_v && (y == 8'hFF) && !m_err;
    m_gd = 0; m_od = 0; m_cd = 0;
    if (pw) m_gd = -1;
    else if (!m_err && s && y_v) m_gd = (y > 1) ? 1 : ((y < 1) ? -1 : 0);
    if (!m_err && p && y_v) m_od = (y < 64) ? 1 : ((y > 64) ? -1 : 0);
    if (!m_err && p && c_v) m_cd = (c < 128) ? 1 : ((c > 128) ? -1 : 0);
    m_g = sat(m_g + m_gd * st);
    m_yo = sat(m_yo + m_od * st);
    m_co = sat(m_co + m_cd * st);
    if (y_v) m_yf = yt ? (y ^ 8'h80) : y;
    if (c_v) m_cf = ct ? (c ^ 8'h80) : c;
    if (pp && !p) begin
      diff = int'(m_blk) - int'(m_tip);
      m_ok = (diff >= 62) && (diff <= 66);
    end
    if (!m_err && s && y_v) m_tip = y;
    if (!m_err && p && y_v) m_blk = y;
    fall = (ps && !s) || (pp && !p);
    ps = s; pp = p;
    if (fall && wins < 16) wins++;
    @(posedge clk); #1;
    chk(y_gain == 10'(m_g), "R1 gain", int'(y_gain), m_g);
    chk(sdir(g_up, g_dn) == m_gd && !(g_up && g_dn), "R1 gain strobe", sdir(g_up, g_dn), m_gd);
    chk(y_ofs == 10'(m_yo) && sdir(yo_up, yo_dn) == m_od, "R2 y offset", int'(y_ofs), m_yo);
    chk(c_ofs == 10'(m_co) && sdir(co_up, co_dn) == m_cd, "R3 c offset", int'(c_ofs), m_co);
    chk(gerr == m_err, "R5 gate error", int'(gerr), int'(m_err));
    chk(sok == m_ok, "R9 sync status", int'(sok), int'(m_ok));
    chk(yf == m_yf && cf == m_cf, "R10 format", int'({yf, cf}), int'({m_yf, m_cf}));
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int g0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(y_gain == 512 && y_ofs == 512 && c_ofs == 512, "R11 integrators", int'(y_gain), 512);
    chk({g_up, g_dn, yo_up, yo_dn, co_up, co_dn, gerr, sok} == 0, "R11 flags", 1, 0);
    chk(yf == 0 && cf == 0, "R11 format", int'(yf), 0);
    @(negedge clk); rst_n = 1;

    // R10 format table; also R6 hold outside windows, R4 enable high has no effect
    foreach (FMT_TAB[i]) begin
      yt = FMT_TAB[i][16]; ct = FMT_TAB[i][16];
      cyc(0, 0, 1, 1, FMT_TAB[i][15:8], FMT_TAB[i][15:8]);
      chk(yf == FMT_TAB[i][7:0], "R10 y table", int'(yf), int'(FMT_TAB[i][7:0]));
      chk(cf == FMT_TAB[i][7:0], "R10 c table", int'(cf), int'(FMT_TAB[i][7:0]));
      chk(y_gain == 512 && !g_up && !g_dn, "R6 hold", int'(y_gain), 512);
    end
    yt = 0; ct = 0;

    // R1 sync window, precharge step
    cyc(1, 0, 1, 0, 8'd10, 8'd0);
    chk(y_gain == 520 && g_up, "R1 R8 up by 8", int'(y_gain), 520);
    g0 = int'(y_gain);
    cyc(1, 0, 1, 0, 8'd1, 8'd0);
    chk(int'(y_gain) == g0 && !g_up && !g_dn, "R1 at target", int'(y_gain), g0);
    cyc(1, 0, 1, 0, 8'd0, 8'd0);
    chk(y_gain == 512 && g_dn, "R1 down", int'(y_gain), 512);
    idle();

    // R2 R3 porch window
    cyc(0, 1, 1, 1, 8'd30, 8'd200);
    chk(y_ofs == 520 && c_ofs == 504, "R2 R3 first step", int'(y_ofs), 520);
    cyc(0, 1, 1, 1, 8'd64, 8'd128);
    cyc(0, 1, 1, 1, 8'd100, 8'd50);
    cyc(0, 1, 0, 0, 8'd0, 8'd0);
    chk(!yo_up && !yo_dn && !co_up && !co_dn, "R6 invalid ignored", int'(y_ofs), m_yo);
    idle();
    chk(sok == 0, "R9 far from nominal", int'(sok), 0);

    // R9 inside and edge of tolerance
    cyc(1, 0, 1, 0, 8'd2, 8'd0); idle();
    cyc(0, 1, 1, 1, 8'd66, 8'd128); idle();
    chk(sok == 1, "R9 diff 64", int'(sok), 1);
    cyc(1, 0, 1, 0, 8'd2, 8'd0); idle();
    cyc(0, 1, 1, 1, 8'd69, 8'd128); idle();
    chk(sok == 0, "R9 diff 67", int'(sok), 0);
    cyc(0, 1, 1, 1, 8'd64, 8'd128); idle();
    chk(sok == 1, "R9 diff 62", int'(sok), 1);

    // R5 overlap
    g0 = int'(y_gain);
    cyc(1, 1, 1, 1, 8'd0, 8'd0);
    chk(gerr && int'(y_gain) == g0 && !g_dn && !yo_up && !co_up, "R5 overlap frozen", int'(y_gain), g0);
    idle();
    chk(!gerr, "R5 flag clears", int'(gerr), 0);

    // R4 peak white
    pw_n = 0;
    g0 = int'(y_gain);
    cyc(0, 0, 1, 0, 8'hFF, 8'd0);
    chk(g_dn && int'(y_gain) == g0 - 8, "R4 outside window", int'(y_gain), g0 - 8);
    cyc(1, 0, 1, 0, 8'hFF, 8'd0);
    chk(g_dn && !g_up, "R4 priority over sync", int'(g_up), 0);
    idle();
    pw_n = 1;
    cyc(1, 0, 1, 0, 8'hFF, 8'd0);
    chk(g_up, "R4 disabled", int'(g_up), 1);
    idle();

    // finish precharge windows
    while (wins < 16) begin
      cyc(0, 1, 1, 1, 8'd64, 8'd128);
      idle();
    end
    g0 = int'(y_gain);
    cyc(1, 0, 1, 0, 8'd10, 8'd0);
    chk(int'(y_gain) == g0 + 1, "R8 single step", int'(y_gain), g0 + 1);
    idle();

    // R7 saturation
    repeat (1100) cyc(1, 0, 1, 0, 8'd0, 8'd0);
    chk(y_gain == 0 && g_dn, "R7 floor", int'(y_gain), 0);
    repeat (1100) cyc(1, 0, 1, 0, 8'd200, 8'd0);
    chk(y_gain == 1023 && g_up, "R7 ceiling", int'(y_gain), 1023);
    idle();
    repeat (1100) cyc(0, 1, 0, 1, 8'd0, 8'd0);
    chk(c_ofs == 1023, "R7 c ceiling", int'(c_ofs), 1023);
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule